// File: doc/BRIEF.md
# Two-Wire Debug Entry Sequencer

This block produces the timed waveform on a clock line and a data line that moves a target device's test logic into two-wire debug mode. A single start pulse launches the sequence. The block first holds the test logic in reset and then activates it. It then gives one short low pulse on the clock line, which latches the mode request, and finishes with a settling wait. Both lines are driven as plain outputs. Switching the data line to tristate for the scans that follow belongs to the logic downstream.

All holds are given in real time and are turned into cycle counts from the `CLK_HZ` parameter when the design is elaborated. Each count is rounded up, so no hold is shorter than its nominal time at any clock frequency. The `busy` output is high for the whole sequence. The `done` output pulses for one cycle once the block is idle again.

Top module: `twdbg_entry_seq`

## Requirements
- R1: After a synchronous reset, and while idle, `ck_o` is 0, `dio_o` is 1, `busy` is 0 and `done` is 0.
- R2: A `start` sampled high while idle sets `busy` on the next cycle. `ck_o` then stays low for ceil(4 ms) + ceil(1 us) cycles, covering the reset hold and the gap.
- R3: `ck_o` then rises and stays high for ceil(20 ms) + ceil(60 us) cycles, covering the activate hold and phase 1.
- R4: `ck_o` then falls and stays low for exactly ceil(1 us) cycles. This is the latch pulse.
- R5: `ck_o` then rises and stays high for ceil(60 us) + ceil(5 ms) cycles. On the following edge `busy` falls and `ck_o` returns low.
- R6: `dio_o` is 1 in every cycle, both during the sequence and while idle.
- R7: `done` is high for exactly one cycle, in the first idle cycle after the sequence, and is never high at any other time.
- R8: A `start` asserted while `busy` is high has no effect, and no phase length changes.
- R9: Each interval count is ceil(t * CLK_HZ), with t in seconds. At 1.5 MHz this gives a 1 us hold of 2 cycles.
- R10: A synchronous reset during the sequence returns the block to the idle state of R1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to run the entry sequence |
| busy | output | 1 | High while the sequence runs |
| done | output | 1 | One-cycle pulse when the sequence has finished |
| ck_o | output | 1 | Clock line to the target |
| dio_o | output | 1 | Data line to the target, driven high |

## Verification
The assertions take `start` to be a level sampled on the rising edge that may arrive in any cycle, including cycles while `busy` is high. They take `rst` to be synchronous and released only on a clock edge. The stimulus drives every input on falling edges, so no input changes at the sampling edge. It inserts start pulses at random offsets inside a running sequence, and it asserts reset at a random point in the middle of the activate hold. Idle gaps between sequences have random lengths drawn from a fixed seed.

// File: rtl/twdbg_entry_seq.sv
module twdbg_entry_seq #(
  parameter longint CLK_HZ = 1_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ck_o,
  output logic dio_o
);

  function automatic longint us2cyc(input longint us);
    longint c;
    c = (us * CLK_HZ + 64'd999_999) / 64'd1_000_000;
    return (c < 1) ? 1 : c;
  endfunction

  localparam longint L_RST = us2cyc(4000);
  localparam longint L_GAP = us2cyc(1);
  localparam longint L_ACT = us2cyc(20000);
  localparam longint L_P1  = us2cyc(60);
  localparam longint L_LAT = us2cyc(1);
  localparam longint L_P4  = us2cyc(60);
  localparam longint L_P5  = us2cyc(5000);
  localparam int CW = $clog2(L_ACT + 1);

  typedef enum logic [2:0] {S_IDLE, S_RST, S_GAP, S_ACT, S_P1, S_LAT, S_P4, S_P5} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          at_end;

  always_comb begin
    case (st)
      S_RST:   last = CW'(L_RST - 1);
      S_GAP:   last = CW'(L_GAP - 1);
      S_ACT:   last = CW'(L_ACT - 1);
      S_P1:    last = CW'(L_P1 - 1);
      S_LAT:   last = CW'(L_LAT - 1);
      S_P4:    last = CW'(L_P4 - 1);
      S_P5:    last = CW'(L_P5 - 1);
      default: last = '0;
    endcase
  end

  assign at_end = (cnt == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        cnt <= '0;
        if (start) st <= S_RST;
      end else if (at_end) begin
        cnt <= '0;
        if (st == S_P5) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end else begin
          st <= st_t'(st + 3'd1);
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign busy  = (st != S_IDLE);
  assign ck_o  = (st == S_ACT) || (st == S_P1) || (st == S_P4) || (st == S_P5);
  assign dio_o = 1'b1;

  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  a_r1_idle_clk_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ck_o);
  a_r8_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= last));
  a_r4_latch_short: assert property (@(posedge clk) disable iff (rst)
    $fell(ck_o) && busy |-> (st == S_LAT));

endmodule

// File: tb/twdbg_entry_seq_tb.sv
module twdbg_entry_seq_tb;
  localparam int     TCK = 10;
  localparam longint HZ1 = 1_000_000;
  localparam longint HZ2 = 1_500_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic b1, d1, c1, o1, b2, d2, c2, o2;
  logic sel = 1'b0;
  int checks = 0;
  int errors = 0;
  int seed_v;

  always #(TCK/2) clk = ~clk;

  twdbg_entry_seq #(.CLK_HZ(HZ1)) u_dut (
    .clk(clk), .rst(rst), .start(start && !sel),
    .busy(b1), .done(d1), .ck_o(c1), .dio_o(o1));

  twdbg_entry_seq #(.CLK_HZ(HZ2)) u_dut2 (
    .clk(clk), .rst(rst), .start(start && sel),
    .busy(b2), .done(d2), .ck_o(c2), .dio_o(o2));

  wire m_busy = sel ? b2 : b1;
  wire m_done = sel ? d2 : d1;
  wire m_ck   = sel ? c2 : c1;
  wire m_dio  = sel ? o2 : o1;

  function automatic int cyc(input longint us, input longint hz);
    return int'((us * hz + 999_999) / 1_000_000);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input longint hz, input int ign1, input int ign2);
    int seg[5];
    int cur, n, bad_dio, early_done;
    for (int i = 0; i < 5; i++) seg[i] = 0;
    cur = 0; n = 0; bad_dio = 0; early_done = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2 busy after start", int'(m_busy), 1);
    while (m_busy && n < 80000) begin
      if (m_dio !== 1'b1) bad_dio++;
      if (m_done) early_done++;
      if (int'(m_ck) != (cur % 2)) cur++;
      if (cur < 5) seg[cur]++;
      start = (n == ign1 || n == ign2);
      n++;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R2 clock low reset+gap", seg[0], cyc(4000, hz) + cyc(1, hz));
    chk("R3 clock high activate+p1", seg[1], cyc(20000, hz) + cyc(60, hz));
    chk("R4 latch low pulse", seg[2], cyc(1, hz));
    chk("R5 clock high p4+p5", seg[3], cyc(60, hz) + cyc(5000, hz));
    chk("R5 no extra segment", seg[4], 0);
    chk("R8 total busy with ignored starts", n,
        cyc(4000, hz) + cyc(1, hz) + cyc(20000, hz) + cyc(60, hz) + cyc(1, hz) + cyc(60, hz) + cyc(5000, hz));
    chk("R6 data high in sequence", bad_dio, 0);
    chk("R7 no done while busy", early_done, 0);
    chk("R7 done at end", int'(m_done), 1);
    chk("R5 clock low at end", int'(m_ck), 0);
    @(negedge clk);
    chk("R7 done one cycle", int'(m_done), 0);
    chk("R6 data high idle", int'(m_dio), 1);
  endtask

  initial begin
    seed_v = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset busy", int'(b1), 0);
    chk("R1 reset done", int'(d1), 0);
    chk("R1 reset clock", int'(c1), 0);
    chk("R1 reset data", int'(o1), 1);

    sel = 1'b0;
    run(HZ1, int'($urandom_range(10, 3000)), int'($urandom_range(5000, 28000)));
    repeat ($urandom_range(1, 20)) @(negedge clk);
    run(HZ1, 0, 4000);

    sel = 1'b1;
    chk("R9 1us rounds up at 1.5MHz", cyc(1, HZ2), 2);
    run(HZ2, int'($urandom_range(100, 40000)), -1);

    sel = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4001 + $urandom_range(10, 5000)) @(negedge clk);
    chk("R10 clock high before reset", int'(c1), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 busy cleared", int'(b1), 0);
    chk("R10 clock low", int'(c1), 0);
    chk("R10 data high", int'(o1), 1);
    chk("R10 no done", int'(d1), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule